// File: doc/BRIEF.md
# Switchable-Placement Tag Directory

This block keeps the tag and valid state of a tiny read-only cache that sits in front of a 256-byte byte-addressed memory. The cache has four lines of four bytes each. It holds no data. For every byte reference presented on the request channel, it reports whether the block was resident. On a miss it allocates the block, and every reference is a read. The memory side, data storage and miss latency are outside this block.

The same four lines can be organised in three ways. Direct-mapped mode has no replacement choice. Two-way set-associative mode evicts the least recently used way of the set. Fully-associative mode evicts the oldest fill, first in first out. The placement mode is captured while reset is held and stays fixed until the next reset. For inspection, every line's valid bit and stored block number are visible on outputs, together with the per-set LRU bits and the FIFO pointer.

The request channel is valid/ready. `req_ready` is held high, so a request is accepted on every clock edge where `req_valid` is high, and back-pressure never occurs. The response channel has no ready. `rsp_valid` pulses for exactly one cycle, one clock after acceptance, and the consumer must take it in that cycle.

Top module: `cache_tag_dir`

## Requirements
- R1: While reset is held low at a clock edge, all line valid bits, LRU bits, the FIFO pointer and `rsp_valid` clear to 0.
- R2: `req_ready` is always 1. A request accepted at an edge produces `rsp_valid`=1 and its `rsp_hit` result after that same edge. `rsp_valid` is 0 after any edge without a request.
- R3: Mode code 0 is direct-mapped. Address bits [3:2] select the line, and a reference hits only if that line is valid and holds the same bits [7:4]. A miss overwrites that line. Bits [1:0] never affect the result.
- R4: Mode code 1 is two-way set-associative. Address bit [2] is the set s. Set s consists of line s (way 0) and line s+2 (way 1). A hit requires a matching bits [7:3] in either way.
- R5: In mode 1, `lru_state` bit s names the way of set s to evict next. A hit or a fill in that set points it at the other way. A miss in a full set replaces the way it names.
- R6: In mode 1, a miss fills an invalid way before evicting anything, preferring way 0.
- R7: Mode code 2 is fully-associative. Any line may hold any block. A miss fills the line named by `fifo_ptr`, which then advances by one modulo 4. Hits leave `fifo_ptr` unchanged.
- R8: Field i of `line_tag` (bits [6i+5:6i]) holds address bits [7:2] of the block resident in line i. Valid bits are only ever set after reset, and a hit changes no line.
- R9: `mode_sel` is sampled only while reset is held. Changes after reset have no effect. Code 3 behaves as code 0.
- R10: For the decimal reference stream 4, 20, 5, 35, 6, 36, 7, 21, 8, 22 from reset, the hit counts are 2, 4 and 5 in modes 0, 1 and 2, and the final contents match the placement rules above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | Placement mode, captured during reset (0 direct, 1 two-way, 2 fully-associative) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_addr | input | 8 | Byte address of the reference |
| rsp_valid | output | 1 | Result present, one cycle after acceptance |
| rsp_hit | output | 1 | 1 = hit, 0 = miss (allocated) |
| line_valid | output | 4 | Valid bit per line |
| line_tag | output | 24 | Resident block number (address bits [7:2]) per line, 6 bits each |
| lru_state | output | 2 | Per-set way to evict next (mode 1) |
| fifo_ptr | output | 2 | Next line to fill (mode 2) |

## Verification
The same ten-reference stream is replayed in each of the three modes. Because its blocks collide on one direct-mapped line, alternate within one two-way set, and overflow the four lines only once, the three different per-reference hit patterns and final contents tell the policies apart. Shorter directed patterns then isolate single rules. Two blocks landing in one set show that invalid ways fill first. Two addresses inside one block show that the offset bits are ignored. A conflict pair that would miss under direct mapping, sent after `mode_sel` is changed post-reset, shows whether the mode was latched at reset.

// File: rtl/ctd_pkg.sv
package ctd_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT = 2'd0,
    MODE_TWOWAY = 2'd1,
    MODE_FULL   = 2'd2,
    MODE_RSVD   = 2'd3
  } place_mode_e;
endpackage

// File: rtl/ctd_tag_match.sv
// Per-line candidate qualification and tag compare; one-hot match encoded to a line index.
module ctd_tag_match
  import ctd_pkg::*;
#(
  parameter int LINES = 4,
  parameter int BLK_W = 6
) (
  input  place_mode_e                   mode,
  input  logic [BLK_W-1:0]              blk,
  input  logic [LINES-1:0]              vld,
  input  logic [LINES*BLK_W-1:0]        tags,
  output logic                          hit,
  output logic [$clog2(LINES)-1:0]      hit_line
);
  localparam int IDX_W = $clog2(LINES);
  localparam int SETS  = LINES / 2;
  localparam int SET_W = $clog2(SETS);

  logic [LINES-1:0] match;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    localparam logic [SET_W-1:0] MY_SET = SET_W'(i % SETS);
    logic cand;
    always_comb begin
      case (mode)
        MODE_TWOWAY: cand = (blk[SET_W-1:0] == MY_SET);
        MODE_FULL:   cand = 1'b1;
        default:     cand = (blk[IDX_W-1:0] == MY_IDX);
      endcase
      match[i] = vld[i] & cand & (tags[i*BLK_W +: BLK_W] == blk);
    end
  end

  always_comb begin
    hit      = |match;
    hit_line = '0;
    for (int i = 0; i < LINES; i++) begin
      if (match[i]) hit_line = IDX_W'(i);
    end
  end
endmodule

// File: rtl/ctd_victim_sel.sv
// Chooses the line a miss fills, per placement mode.
module ctd_victim_sel
  import ctd_pkg::*;
#(
  parameter int LINES = 4,
  parameter int BLK_W = 6
) (
  input  place_mode_e                   mode,
  input  logic [BLK_W-1:0]              blk,
  input  logic [LINES-1:0]              vld,
  input  logic [LINES/2-1:0]            lru,
  input  logic [$clog2(LINES)-1:0]      fifo_ptr,
  output logic [$clog2(LINES)-1:0]      fill_line
);
  localparam int IDX_W = $clog2(LINES);
  localparam int SET_W = $clog2(LINES / 2);

  logic [SET_W-1:0] set;
  logic [IDX_W-1:0] way0_line, way1_line;

  assign set       = blk[SET_W-1:0];
  assign way0_line = {1'b0, set};
  assign way1_line = {1'b1, set};

  always_comb begin
    case (mode)
      MODE_TWOWAY: begin
        if (!vld[way0_line])      fill_line = way0_line;
        else if (!vld[way1_line]) fill_line = way1_line;
        else                      fill_line = {lru[set], set};
      end
      MODE_FULL: fill_line = fifo_ptr;
      default:   fill_line = blk[IDX_W-1:0];
    endcase
  end
endmodule

// File: rtl/ctd_repl_state.sv
// Replacement bookkeeping: per-set LRU bits and a global fill pointer.
module ctd_repl_state
  import ctd_pkg::*;
#(
  parameter int LINES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  place_mode_e                   mode,
  input  logic                          upd,
  input  logic                          miss,
  input  logic [$clog2(LINES/2)-1:0]    set,
  input  logic                          way,
  output logic [LINES/2-1:0]            lru,
  output logic [$clog2(LINES)-1:0]      fifo_ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lru      <= '0;
      fifo_ptr <= '0;
    end else if (upd) begin
      if (mode == MODE_TWOWAY) lru[set] <= ~way;
      if (mode == MODE_FULL && miss) fifo_ptr <= fifo_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
  import ctd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OFFS_W = 2,
  parameter int LINES  = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [1:0]                          mode_sel,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic [ADDR_W-1:0]                   req_addr,
  output logic                                rsp_valid,
  output logic                                rsp_hit,
  output logic [LINES-1:0]                    line_valid,
  output logic [LINES*(ADDR_W-OFFS_W)-1:0]    line_tag,
  output logic [LINES/2-1:0]                  lru_state,
  output logic [$clog2(LINES)-1:0]            fifo_ptr
);
  localparam int BLK_W = ADDR_W - OFFS_W;
  localparam int IDX_W = $clog2(LINES);
  localparam int SET_W = $clog2(LINES / 2);

  place_mode_e               mode_q;
  logic [LINES-1:0]          vld_q;
  logic [LINES*BLK_W-1:0]    tag_q;
  logic [BLK_W-1:0]          blk;
  logic                      hit;
  logic [IDX_W-1:0]          hit_line, fill_line, touched;

  assign req_ready  = 1'b1;
  assign blk        = req_addr[ADDR_W-1:OFFS_W];
  assign touched    = hit ? hit_line : fill_line;
  assign line_valid = vld_q;
  assign line_tag   = tag_q;

  // Mode is latched only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= place_mode_e'(mode_sel);
  end

  ctd_tag_match #(.LINES(LINES), .BLK_W(BLK_W)) u_match (
    .mode(mode_q), .blk(blk), .vld(vld_q), .tags(tag_q),
    .hit(hit), .hit_line(hit_line)
  );

  ctd_victim_sel #(.LINES(LINES), .BLK_W(BLK_W)) u_victim (
    .mode(mode_q), .blk(blk), .vld(vld_q), .lru(lru_state),
    .fifo_ptr(fifo_ptr), .fill_line(fill_line)
  );

  ctd_repl_state #(.LINES(LINES)) u_repl (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .upd(req_valid), .miss(!hit),
    .set(blk[SET_W-1:0]), .way(touched[IDX_W-1]),
    .lru(lru_state), .fifo_ptr(fifo_ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q     <= '0;
      tag_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit <= hit;
        if (!hit) begin
          vld_q[fill_line]                  <= 1'b1;
          tag_q[fill_line*BLK_W +: BLK_W]   <= blk;
        end
      end
    end
  end
endmodule

// File: rtl/ctd_checker.sv
module ctd_checker
  import ctd_pkg::*;
#(
  parameter int LINES = 4,
  parameter int BLK_W = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic                        rsp_valid,
  input logic                        rsp_hit,
  input logic [LINES-1:0]            line_valid,
  input logic [LINES*BLK_W-1:0]      line_tag,
  input logic [LINES/2-1:0]          lru_state,
  input logic [$clog2(LINES)-1:0]    fifo_ptr,
  input place_mode_e                 mode_q
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_HIT_KEEPS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> ($stable(line_valid) && $stable(line_tag))); // R8
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((line_valid & $past(line_valid)) == $past(line_valid))); // R8
  AST_FIFO_HOLD_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> $stable(fifo_ptr)); // R7
  AST_FIFO_STEP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && mode_q == MODE_FULL) |-> (fifo_ptr == $past(fifo_ptr) + 1'b1)); // R7
  AST_LRU_IDLE_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_TWOWAY) |-> (lru_state == '0)); // R5
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_q)); // R9
endmodule

bind cache_tag_dir ctd_checker #(.LINES(LINES), .BLK_W(ADDR_W - OFFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .line_valid(line_valid), .line_tag(line_tag),
  .lru_state(lru_state), .fifo_ptr(fifo_ptr), .mode_q(mode_q)
);

// File: tb/cache_tag_dir_test.sv
module cache_tag_dir_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = 8'd0;
  logic        rsp_valid, rsp_hit;
  logic [3:0]  line_valid;
  logic [23:0] line_tag;
  logic [1:0]  lru_state;
  logic [1:0]  fifo_ptr;

  int n_chk = 0;
  int n_bad = 0;
  int hits;

  always #4 clk = ~clk;

  cache_tag_dir uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .line_valid(line_valid), .line_tag(line_tag),
    .lru_state(lru_state), .fifo_ptr(fifo_ptr)
  );

  logic [7:0] stream [10] = '{8'd4, 8'd20, 8'd5, 8'd35, 8'd6, 8'd36, 8'd7, 8'd21, 8'd8, 8'd22};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tag_of(input int i);
    return int'(line_tag[i*6 +: 6]);
  endfunction

  // Holds reset with the given mode, then checks the cleared state (R1).
  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode_sel = m; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(line_valid == 4'b0 && rsp_valid == 1'b0, "R1 cleared lines/rsp",
          int'(line_valid), 0);
    check(lru_state == 2'b0 && fifo_ptr == 2'b0, "R1 cleared lru/fifo",
          int'({lru_state, fifo_ptr}), 0);
    rst_n = 1'b1;
  endtask

  // One reference, result checked at the negedge after the accepting edge.
  task automatic do_ref(input logic [7:0] a, input bit exp_hit, input string req);
    req_valid = 1'b1; req_addr = a;
    check(req_ready == 1'b1, "R2 ready", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, "R2 rsp_valid", int'(rsp_valid), 1);
    check(rsp_hit == exp_hit, req, int'(rsp_hit), int'(exp_hit));
    if (rsp_hit) hits++;
  endtask

  task automatic t_stream(input logic [1:0] m, input logic [9:0] exp_hits, input int exp_cnt);
    do_reset(m);
    hits = 0;
    for (int k = 0; k < 10; k++) do_ref(stream[k], exp_hits[k], "R10 per-ref hit");
    check(hits == exp_cnt, "R10 hit count", hits, exp_cnt);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R2 rsp drops when idle", int'(rsp_valid), 0);
  endtask

  task automatic t_direct;
    t_stream(2'd0, 10'b1000010000, 2);
    check(line_valid == 4'b0111, "R3 final valid", int'(line_valid), 7);
    check(tag_of(0) == 8 && tag_of(1) == 5 && tag_of(2) == 2, "R8 direct tags",
          tag_of(1), 5);
    // R3: offset bits ignored, same block different byte
    do_ref(8'd9, 1'b1, "R3 offset ignored");
    do_ref(8'd40, 1'b0, "R3 conflict miss");
    check(tag_of(2) == 10, "R3 line 2 overwritten", tag_of(2), 10);
  endtask

  task automatic t_twoway;
    t_stream(2'd1, 10'b1001010100, 4);
    check(line_valid == 4'b1111, "R4 final valid", int'(line_valid), 15);
    check(tag_of(0) == 8 && tag_of(1) == 1 && tag_of(2) == 2 && tag_of(3) == 5,
          "R4 two-way tags", tag_of(3), 5);
    check(lru_state == 2'b00, "R5 final lru", int'(lru_state), 0);
    // R5: set 1 full (1 in way0, 5 in way1); lru names way0 -> block 13 evicts line 1
    do_ref(8'd52, 1'b0, "R5 lru evict miss");
    check(tag_of(1) == 13 && tag_of(3) == 5, "R5 victim is lru way", tag_of(1), 13);
    check(lru_state == 2'b10, "R5 lru flips after fill", int'(lru_state), 2);
    do_ref(8'd20, 1'b1, "R5 survivor hits");
    check(lru_state == 2'b00, "R5 lru after hit", int'(lru_state), 0);
  endtask

  task automatic t_twoway_invalid;
    do_reset(2'd1);
    do_ref(8'd12, 1'b0, "R6 first fill");
    check(line_valid == 4'b0010, "R6 way0 first", int'(line_valid), 2);
    do_ref(8'd28, 1'b0, "R6 second fill");
    check(line_valid == 4'b1010 && tag_of(3) == 7, "R6 way1 next", int'(line_valid), 10);
    check(lru_state == 2'b00, "R5 lru after way1 fill", int'(lru_state), 0);
    do_ref(8'd13, 1'b1, "R4 way0 hit");
  endtask

  task automatic t_full;
    t_stream(2'd2, 10'b1011010100, 5);
    check(line_valid == 4'b1111, "R7 final valid", int'(line_valid), 15);
    check(tag_of(0) == 2 && tag_of(1) == 5 && tag_of(2) == 8 && tag_of(3) == 9,
          "R7 fifo tags", tag_of(0), 2);
    check(fifo_ptr == 2'd1, "R7 fifo pointer", int'(fifo_ptr), 1);
    do_ref(8'd36, 1'b1, "R7 hit keeps order");
    check(fifo_ptr == 2'd1, "R7 pointer held on hit", int'(fifo_ptr), 1);
    do_ref(8'd100, 1'b0, "R7 next eviction");
    check(tag_of(1) == 25 && fifo_ptr == 2'd2, "R7 line 1 replaced", tag_of(1), 25);
  endtask

  task automatic t_mode_latch;
    do_reset(2'd2);
    mode_sel = 2'd0;
    do_ref(8'd0, 1'b0, "R9 first");
    do_ref(8'd16, 1'b0, "R9 second");
    do_ref(8'd1, 1'b1, "R9 mode held fully-assoc");
    check(line_valid == 4'b0011, "R9 two lines used", int'(line_valid), 3);
  endtask

  task automatic t_reserved;
    do_reset(2'd3);
    do_ref(8'd0, 1'b0, "R9 code3 first");
    do_ref(8'd16, 1'b0, "R9 code3 conflict");
    do_ref(8'd0, 1'b0, "R9 code3 acts direct");
  endtask

  initial begin
    fork
      begin
        t_direct;
        t_twoway;
        t_twoway_invalid;
        t_full;
        t_mode_latch;
        t_reserved;
      end
      begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule